// File: doc/BRIEF.md
# Dual-Group Sample Trigger Sequencer

This block is the conversion-control logic of an eight-channel simultaneous-sampling converter. The channels form two groups of four, and each group has its own start input. A rising edge on a group's start input moves that group's track-and-hold control into hold at once. The shared conversion is requested only after both groups are holding. The busy flag covers the whole conversion, which is modelled as a fixed count of clock cycles. When busy falls, both groups go back to track.

The start inputs are asynchronous. Each passes through a two-stage synchronizer and a rising-edge detector. When oversampling is enabled, split triggering is not allowed, so an edge on either input samples both groups together. The gap between the first and second group edge is measured. If the gap is longer than a set limit, a sticky error flag is raised, and the conversion still starts. Start edges that arrive during a conversion have no effect on it. They are counted in a saturating counter.

Top module: `dual_group_trigger`

## Requirements
- R1: After reset, holdA, holdB, busy, convReq and skewErr are 0 and ovrCount is 0.
- R2: A rising edge on startA (set up before clock edge k) drives holdA to 1 after edge k+2. holdB and busy stay 0 while the B group has not been triggered.
- R3: A rising edge on startB alone drives holdB to 1 with the same three-edge latency. holdA and busy stay 0.
- R4: busy rises on the edge that registers the later of the two group triggers. convReq is 1 for exactly that one cycle.
- R5: When startA and startB rise together, holdA, holdB and busy all become 1 on the same edge.
- R6: busy stays high for exactly CONV_CYCLES clock cycles per conversion and falls once.
- R7: On the edge where busy falls, holdA and holdB both return to 0.
- R8: While ovsEn is 1, a rising edge on only one start input puts both groups into hold and starts the conversion.
- R9: A second group edge detected more than SKEW_MAX cycles after the first sets skewErr, which then stays 1 until reset. The conversion still starts. A gap of exactly SKEW_MAX cycles leaves skewErr at 0.
- R10: Start edges detected while busy is high leave busy, its length and both holds unchanged. Each one increments ovrCount, which saturates at 2^OVR_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startA | input | 1 | Asynchronous start for channels 1 to 4 |
| startB | input | 1 | Asynchronous start for channels 5 to 8 |
| ovsEn | input | 1 | Oversampling enabled; forces joint triggering |
| holdA | output | 1 | 1 = group A in hold, 0 = track |
| holdB | output | 1 | 1 = group B in hold, 0 = track |
| busy | output | 1 | Conversion in progress |
| convReq | output | 1 | One-cycle request to the conversion engine |
| skewErr | output | 1 | Sticky: group gap exceeded SKEW_MAX |
| ovrCount | output | OVR_W | Saturating count of start edges ignored while busy |

## Verification
The assertions assume that each start pulse is held for at least one clock cycle, and that pulses are separated by at least one low cycle, so that every intended edge survives synchronization. They also assume that ovsEn does not change while a group is waiting for its partner. The stimulus drives every input on the falling clock edge and keeps each pulse one cycle high and at least one cycle low. It changes ovsEn only while the block is idle, and it spaces the two group triggers by a known count of cycles, so that each skew case sits on a chosen side of the limit.

// File: rtl/dgt_pkg.sv
package dgt_pkg;
  // strobes issued by the control unit to the datapath
  typedef struct packed {
    logic launch;     // start conversion counter, stop skew timer
    logic skewStart;  // first group captured, start skew timer
    logic ovrInc;     // a start edge was ignored during busy
  } dgtStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_A,
    ST_WAIT_B,
    ST_BUSY
  } dgtState_t;
endpackage

// File: rtl/dgt_datapath.sv
module dgt_datapath
  import dgt_pkg::*;
#(
  parameter int CONV_CYCLES = 160,
  parameter int SKEW_MAX    = 100,
  parameter int OVR_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startA,
  input  logic             startB,
  input  dgtStrobe_t       strobe,
  output logic             edgeA,
  output logic             edgeB,
  output logic             convDone,
  output logic             skewExpired,
  output logic [OVR_W-1:0] ovrCount
);
  localparam int CONV_W = $clog2(CONV_CYCLES + 1);
  localparam int SKEW_W = $clog2(SKEW_MAX + 1);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  logic [1:0] startVec;
  logic [1:0] edgeVec;
  assign startVec = {startB, startA};

  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC_STAGES-1:0] shiftQ;
    logic                   prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftQ <= '0;
        prevQ  <= 1'b0;
      end else begin
        shiftQ <= {shiftQ[SYNC_STAGES-2:0], startVec[g]};
        prevQ  <= shiftQ[SYNC_STAGES-1];
      end
    end
    assign edgeVec[g] = shiftQ[SYNC_STAGES-1] & ~prevQ;
  end

  assign edgeA = edgeVec[0];
  assign edgeB = edgeVec[1];

  // conversion time counter
  logic              convActive;
  logic [CONV_W-1:0] convCnt;
  assign convDone = convActive && (convCnt == CONV_W'(CONV_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convActive <= 1'b0;
      convCnt    <= '0;
    end else if (strobe.launch) begin
      convActive <= 1'b1;
      convCnt    <= '0;
    end else if (convDone) begin
      convActive <= 1'b0;
    end else if (convActive) begin
      convCnt <= convCnt + 1'b1;
    end
  end

  // skew timer between the two group edges, saturating at the limit
  logic              skewActive;
  logic [SKEW_W-1:0] skewCnt;
  assign skewExpired = skewActive && (skewCnt == SKEW_W'(SKEW_MAX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skewActive <= 1'b0;
      skewCnt    <= '0;
    end else if (strobe.launch) begin
      skewActive <= 1'b0;
    end else if (strobe.skewStart) begin
      skewActive <= 1'b1;
      skewCnt    <= '0;
    end else if (skewActive && !skewExpired) begin
      skewCnt <= skewCnt + 1'b1;
    end
  end

  // saturating overrun counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrCount <= '0;
    end else if (strobe.ovrInc && ovrCount != OVR_MAX) begin
      ovrCount <= ovrCount + 1'b1;
    end
  end

  // R6
  conv_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    convActive |-> (convCnt < CONV_W'(CONV_CYCLES)));

  // R9
  skew_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    skewActive |-> (skewCnt <= SKEW_W'(SKEW_MAX)));

  // R10
  ovr_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovrCount == OVR_MAX) |=> (ovrCount == OVR_MAX));

  // R10
  ovr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ovrInc |=> $stable(ovrCount));
endmodule

// File: rtl/dgt_control.sv
module dgt_control
  import dgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ovsEn,
  input  logic       edgeA,
  input  logic       edgeB,
  input  logic       convDone,
  input  logic       skewExpired,
  output dgtStrobe_t strobe,
  output logic       holdA,
  output logic       holdB,
  output logic       busy,
  output logic       convReq,
  output logic       skewErr
);
  dgtState_t state, stateNxt;
  logic holdANxt, holdBNxt, convReqNxt;
  logic jointTrig;

  assign jointTrig = (edgeA && edgeB) || (ovsEn && (edgeA || edgeB));
  assign busy      = (state == ST_BUSY);

  always_comb begin
    stateNxt   = state;
    holdANxt   = holdA;
    holdBNxt   = holdB;
    convReqNxt = 1'b0;
    strobe     = '0;
    unique case (state)
      ST_IDLE: begin
        if (jointTrig) begin
          holdANxt      = 1'b1;
          holdBNxt      = 1'b1;
          convReqNxt    = 1'b1;
          strobe.launch = 1'b1;
          stateNxt      = ST_BUSY;
        end else if (edgeA) begin
          holdANxt         = 1'b1;
          strobe.skewStart = 1'b1;
          stateNxt         = ST_WAIT_B;
        end else if (edgeB) begin
          holdBNxt         = 1'b1;
          strobe.skewStart = 1'b1;
          stateNxt         = ST_WAIT_A;
        end
      end
      ST_WAIT_B: begin
        if (edgeB) begin
          holdBNxt      = 1'b1;
          convReqNxt    = 1'b1;
          strobe.launch = 1'b1;
          stateNxt      = ST_BUSY;
        end
      end
      ST_WAIT_A: begin
        if (edgeA) begin
          holdANxt      = 1'b1;
          convReqNxt    = 1'b1;
          strobe.launch = 1'b1;
          stateNxt      = ST_BUSY;
        end
      end
      ST_BUSY: begin
        strobe.ovrInc = edgeA || edgeB;
        if (convDone) begin
          holdANxt = 1'b0;
          holdBNxt = 1'b0;
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      holdA   <= 1'b0;
      holdB   <= 1'b0;
      convReq <= 1'b0;
      skewErr <= 1'b0;
    end else begin
      state   <= stateNxt;
      holdA   <= holdANxt;
      holdB   <= holdBNxt;
      convReq <= convReqNxt;
      skewErr <= skewErr | skewExpired;
    end
  end

  // R4
  busy_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> convReq);

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convReq |=> !convReq);

  // R7
  track_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!holdA && !holdB));

  // R10
  hold_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (holdA && holdB));

  // R9
  skew_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    skewErr |=> skewErr);
endmodule

// File: rtl/dual_group_trigger.sv
module dual_group_trigger
  import dgt_pkg::*;
#(
  parameter int CONV_CYCLES = 160,
  parameter int SKEW_MAX    = 100,
  parameter int OVR_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startA,
  input  logic             startB,
  input  logic             ovsEn,
  output logic             holdA,
  output logic             holdB,
  output logic             busy,
  output logic             convReq,
  output logic             skewErr,
  output logic [OVR_W-1:0] ovrCount
);
  dgtStrobe_t strobe;
  logic edgeA, edgeB, convDone, skewExpired;

  dgt_datapath #(
    .CONV_CYCLES(CONV_CYCLES),
    .SKEW_MAX   (SKEW_MAX),
    .OVR_W      (OVR_W),
    .SYNC_STAGES(2)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .startA     (startA),
    .startB     (startB),
    .strobe     (strobe),
    .edgeA      (edgeA),
    .edgeB      (edgeB),
    .convDone   (convDone),
    .skewExpired(skewExpired),
    .ovrCount   (ovrCount)
  );

  dgt_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .ovsEn      (ovsEn),
    .edgeA      (edgeA),
    .edgeB      (edgeB),
    .convDone   (convDone),
    .skewExpired(skewExpired),
    .strobe     (strobe),
    .holdA      (holdA),
    .holdB      (holdB),
    .busy       (busy),
    .convReq    (convReq),
    .skewErr    (skewErr)
  );
endmodule

// File: tb/test_dual_group_trigger.sv
module test_dual_group_trigger;
  localparam int CONV = 40;
  localparam int SKEW = 5;
  localparam int OW   = 3;

  logic clk = 1'b0;
  logic rstN, startA, startB, ovsEn;
  logic holdA, holdB, busy, convReq, skewErr;
  logic [OW-1:0] ovrCount;
  int checks = 0;
  int errors = 0;
  int busyCycles = 0;

  always #2 clk = ~clk;

  dual_group_trigger #(.CONV_CYCLES(CONV), .SKEW_MAX(SKEW), .OVR_W(OW)) i_dual_group_trigger (
    .clk(clk), .rstN(rstN), .startA(startA), .startB(startB), .ovsEn(ovsEn),
    .holdA(holdA), .holdB(holdB), .busy(busy), .convReq(convReq),
    .skewErr(skewErr), .ovrCount(ovrCount)
  );

  always @(negedge clk) if (busy === 1'b1) busyCycles++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // set at the current falling edge, clear at the next one
  task automatic pulse(input logic a, input logic b);
    startA = a;
    startB = b;
    @(negedge clk);
    startA = 1'b0;
    startB = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; startA = 1'b0; startB = 1'b0; ovsEn = 1'b0;
    waitN(3);
    rstN = 1'b1;
    waitN(1);
  endtask

  task automatic waitIdle();
    for (int g = 0; g < 1000 && busy; g++) @(negedge clk);
  endtask

  task automatic finishConv(input int base, input string tag);
    waitIdle();
    chk({tag, " R6 busy length"}, busyCycles - base, CONV);
    chk({tag, " R7 holdA back to track"}, holdA, 0);
    chk({tag, " R7 holdB back to track"}, holdB, 0);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 holdA", holdA, 0);
    chk("R1 holdB", holdB, 0);
    chk("R1 busy", busy, 0);
    chk("R1 convReq", convReq, 0);
    chk("R1 skewErr", skewErr, 0);
    chk("R1 ovrCount", ovrCount, 0);
  endtask

  // gap >= 3: cycles between the first and second trigger
  task automatic testSplit(input bit firstA, input int gap, input int expSkew, input string tag);
    int base;
    base = busyCycles;
    pulse(firstA, !firstA);
    waitN(1);
    chk({tag, " R2 no hold before sync latency"}, firstA ? holdA : holdB, 0);
    waitN(1);
    if (firstA) begin
      chk({tag, " R2 holdA set"}, holdA, 1);
      chk({tag, " R2 holdB still track"}, holdB, 0);
    end else begin
      chk({tag, " R3 holdB set"}, holdB, 1);
      chk({tag, " R3 holdA still track"}, holdA, 0);
    end
    chk({tag, " R4 busy waits for second group"}, busy, 0);
    waitN(gap - 3);
    pulse(!firstA, firstA);
    waitN(1);
    chk({tag, " R4 busy low before later edge registered"}, busy, 0);
    waitN(1);
    chk({tag, " R4 busy on later edge"}, busy, 1);
    chk({tag, " R4 convReq on later edge"}, convReq, 1);
    chk({tag, " R4 both held"}, holdA & holdB, 1);
    chk({tag, " R9 skewErr"}, skewErr, expSkew);
    waitN(1);
    chk({tag, " R4 convReq one cycle"}, convReq, 0);
    finishConv(base, tag);
    chk({tag, " R9 skewErr after conversion"}, skewErr, expSkew);
  endtask

  task automatic testJoint();
    int base;
    base = busyCycles;
    pulse(1'b1, 1'b1);
    waitN(1);
    chk("R5 nothing before latency", holdA | holdB | busy, 0);
    waitN(1);
    chk("R5 holdA", holdA, 1);
    chk("R5 holdB", holdB, 1);
    chk("R5 busy", busy, 1);
    finishConv(base, "joint");
  endtask

  task automatic testOvs();
    int base;
    ovsEn = 1'b1;
    base = busyCycles;
    pulse(1'b0, 1'b1);
    waitN(2);
    chk("R8 holdA via B edge", holdA, 1);
    chk("R8 holdB", holdB, 1);
    chk("R8 busy", busy, 1);
    chk("R8 convReq", convReq, 1);
    finishConv(base, "ovs");
    ovsEn = 1'b0;
  endtask

  task automatic testOverrun();
    int base;
    doReset();
    base = busyCycles;
    pulse(1'b1, 1'b1);
    waitN(2);
    chk("R10 conversion started", busy, 1);
    for (int i = 0; i < 3; i++) begin pulse(1'b1, 1'b0); waitN(1); end
    waitN(2);
    chk("R10 ovrCount counts ignored edges", ovrCount, 3);
    chk("R10 busy unaffected", busy, 1);
    chk("R10 holds unaffected", holdA & holdB, 1);
    for (int i = 0; i < 6; i++) begin pulse(i[0], !i[0]); waitN(1); end
    waitN(2);
    chk("R10 ovrCount saturates", ovrCount, 7);
    finishConv(base, "overrun R10");
    chk("R10 ovrCount after conversion", ovrCount, 7);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testSplit(1'b1, 3, 0, "A then B");
    testSplit(1'b0, 4, 0, "B then A");
    testJoint();
    testOvs();
    doReset();
    testSplit(1'b1, SKEW, 0, "gap at limit");
    doReset();
    testSplit(1'b0, SKEW + 1, 1, "gap over limit");
    testOverrun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule